// File: doc/BRIEF.md
# UART Interrupt Event Generator

This block collects the status lines of a serial port and its two-buffer DMA channels and turns them into interrupt flags. Ten sources are watched. Three follow the state of the FIFOs: the transmitter has gone idle, the transmit FIFO has room, and the receive FIFO holds data. Four mark the end of a DMA buffer, one each for transmit buffer A and B and receive buffer A and B. Three mark receive errors: parity, framing and overrun.

A single mode input decides how the three FIFO-state sources behave. In edge mode each one latches on a rising edge of its status line. In level mode the flag tracks the status line itself. A DMA buffer source latches when its busy bit falls from 1 to 0. An error source latches when its pulse input is high on a clock edge. Latched flags stay set until software writes a 1 to them. A per-source enable mask and one global enable qualify the flags into a single registered interrupt request.

Top module: `uart_irq_events`

## Requirements
- R1: While `rst_n` is low, `flags` and `irq` are all zero.
- R2: With `level_mode` = 0, a 0-to-1 change on `tx_idle`, `tx_free` or `rx_avail` sets flag bit 0, 1 or 2 in the cycle after the high value is first sampled. A line that stays high does not set the flag again once it has been cleared.
- R3: With `level_mode` = 1, flag bits 0 to 2 equal the value of their status line at the previous clock edge. A clear write has no effect on them.
- R4: A 1-to-0 change on `tx_buf_busy[0]`, `tx_buf_busy[1]`, `rx_buf_busy[0]` or `rx_buf_busy[1]` sets flag bit 3, 4, 5 or 6, one cycle after the low value is first sampled.
- R5: A high sample on `parity_err`, `frame_err` or `overrun_err` sets flag bit 7, 8 or 9 one cycle later.
- R6: A cycle with `clr_we` = 1 clears every latched flag whose `clr_mask` bit is 1, effective one cycle later. Flags whose mask bit is 0 are left unchanged. If a source event arrives in the same cycle as its clear, the flag stays set.
- R7: Status lines that are already high or low while reset is held produce no flag after reset is released.
- R8: `irq` is registered. It is 1 in exactly the cycles where `glb_en` and `src_en` were set at the previous edge and at least one flag enabled by `src_en` is set. It rises in the same cycle as the flag that causes it.
- R9: With `glb_en` = 0, `irq` is 0 in the following cycle. The flags keep latching as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_mode | input | 1 | 1: FIFO-state flags follow their level; 0: they latch on a rising edge |
| tx_idle | input | 1 | Transmit FIFO empty and last character shifted out |
| tx_free | input | 1 | Transmit FIFO not full |
| rx_avail | input | 1 | Receive FIFO not empty |
| tx_buf_busy | input | 2 | Transmit DMA buffer B/A active (bit 1 = B) |
| rx_buf_busy | input | 2 | Receive DMA buffer B/A active (bit 1 = B) |
| parity_err | input | 1 | Pulse: character received with a parity error |
| frame_err | input | 1 | Pulse: character received with a framing error |
| overrun_err | input | 1 | Pulse: character lost because the receive FIFO was full |
| clr_we | input | 1 | Strobe for a write-one-to-clear of the flags |
| clr_mask | input | 10 | Flags to clear when `clr_we` is high |
| src_en | input | 10 | Per-source interrupt enable |
| glb_en | input | 1 | Global interrupt enable |
| flags | output | 10 | Source flags |
| irq | output | 1 | Interrupt request |

## Verification
Each source flag is due exactly one clock edge after the stimulus that causes it, and `irq` is due at that same edge, because it is formed from the next-state flags.

The bench changes its inputs 2 ns after each rising edge. A reference model updates on the rising edge from those input values, and its results are compared with the outputs at every falling edge.

Directed checks are read 2 ns after the edge that must have produced the result, never earlier. This covers each edge rule, the clear-versus-set race and the two enable stages. A long randomized run then checks mode changes and overlapping events against the model on every cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

  localparam int NUM_LVL_SRC = 3;
  localparam int NUM_DMA_SRC = 4;
  localparam int NUM_ERR_SRC = 3;
  localparam int NUM_STAT    = NUM_LVL_SRC + NUM_DMA_SRC;
  localparam int NUM_SRC     = NUM_STAT + NUM_ERR_SRC;

  localparam int B_TX_IDLE  = 0;
  localparam int B_TX_FREE  = 1;
  localparam int B_RX_AVAIL = 2;
  localparam int B_TXA_DONE = 3;
  localparam int B_PARITY   = 7;
  localparam int B_FRAME    = 8;
  localparam int B_OVERRUN  = 9;

  // status bits whose event is a falling edge (the DMA busy lines)
  localparam logic [NUM_STAT-1:0] FALL_MASK =
    {{NUM_DMA_SRC{1'b1}}, {NUM_LVL_SRC{1'b0}}};

  typedef logic [NUM_SRC-1:0]  src_vec_t;
  typedef logic [NUM_STAT-1:0] stat_vec_t;

  function automatic logic edge_event(logic falling, logic cur, logic prev);
    return falling ? (prev & ~cur) : (cur & ~prev);
  endfunction

  function automatic logic next_flag(logic lvl, logic live, logic evt,
                                     logic clr, logic cur);
    return lvl ? live : (evt | (cur & ~clr));
  endfunction

  function automatic logic any_enabled(src_vec_t f, src_vec_t en, logic g);
    return g & (|(f & en));
  endfunction

endpackage

// File: rtl/uirq_edge_detect.sv
module uirq_edge_detect #(
  parameter int W = 7,
  parameter logic [W-1:0] FALL = '0
) (
  input  logic         clk,
  input  logic [W-1:0] stat_i,
  output logic [W-1:0] evt_o
);

  // Copy reloads every cycle, including during reset, so no
  // false edge appears when reset is released.
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    prev_q <= stat_i;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign evt_o[i] = uirq_pkg::edge_event(FALL[i], stat_i[i], prev_q[i]);
  end

endmodule

// File: rtl/uirq_flag_bank.sv
module uirq_flag_bank #(
  parameter int N    = 10,
  parameter int NLVL = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            level_mode,
  input  logic [NLVL-1:0] lvl_sig,
  input  logic [N-1:0]    evt,
  input  logic            clr_we,
  input  logic [N-1:0]    clr_mask,
  output logic [N-1:0]    flag_d_o,
  output logic [N-1:0]    flag_q_o
);

  logic [N-1:0] clr_hit;
  assign clr_hit = clr_we ? clr_mask : '0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (i < NLVL) begin : g_fifo
      assign flag_d_o[i] = uirq_pkg::next_flag(level_mode, lvl_sig[i], evt[i],
                                               clr_hit[i], flag_q_o[i]);

      p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && evt[i]) |=> flag_q_o[i]);

      p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (flag_q_o[i] == $past(lvl_sig[i])));

      p_edge_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && clr_we && clr_mask[i] && !evt[i]) |=> !flag_q_o[i]);
    end else begin : g_sticky
      assign flag_d_o[i] = uirq_pkg::next_flag(1'b0, 1'b0, evt[i],
                                               clr_hit[i], flag_q_o[i]);

      p_sticky_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && clr_mask[i] && !evt[i]) |=> !flag_q_o[i]);

      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        evt[i] |=> flag_q_o[i]);

      p_sticky_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q_o[i] && !(clr_we && clr_mask[i])) |=> flag_q_o[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q_o <= '0;
    else        flag_q_o <= flag_d_o;
  end

endmodule

// File: rtl/uirq_req_combine.sv
module uirq_req_combine (
  input  logic               clk,
  input  logic               rst_n,
  input  uirq_pkg::src_vec_t flag_d,
  input  uirq_pkg::src_vec_t flag_q,
  input  uirq_pkg::src_vec_t src_en,
  input  logic               glb_en,
  output logic               irq_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= uirq_pkg::any_enabled(flag_d, src_en, glb_en);
  end

  p_global_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !irq_o);

  p_irq_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((|(flag_q & $past(src_en))) && $past(glb_en)));

endmodule

// File: rtl/uart_irq_events.sv
module uart_irq_events (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         level_mode,
  input  logic                         tx_idle,
  input  logic                         tx_free,
  input  logic                         rx_avail,
  input  logic [1:0]                   tx_buf_busy,
  input  logic [1:0]                   rx_buf_busy,
  input  logic                         parity_err,
  input  logic                         frame_err,
  input  logic                         overrun_err,
  input  logic                         clr_we,
  input  logic [uirq_pkg::NUM_SRC-1:0] clr_mask,
  input  logic [uirq_pkg::NUM_SRC-1:0] src_en,
  input  logic                         glb_en,
  output logic [uirq_pkg::NUM_SRC-1:0] flags,
  output logic                         irq
);

  import uirq_pkg::*;

  stat_vec_t stat;
  stat_vec_t stat_evt;
  src_vec_t  src_evt;
  src_vec_t  flag_d;

  assign stat    = {rx_buf_busy, tx_buf_busy, rx_avail, tx_free, tx_idle};
  assign src_evt = {overrun_err, frame_err, parity_err, stat_evt};

  uirq_edge_detect #(.W(NUM_STAT), .FALL(FALL_MASK)) u_edge (
    .clk    (clk),
    .stat_i (stat),
    .evt_o  (stat_evt)
  );

  uirq_flag_bank #(.N(NUM_SRC), .NLVL(NUM_LVL_SRC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .level_mode (level_mode),
    .lvl_sig    (stat[NUM_LVL_SRC-1:0]),
    .evt        (src_evt),
    .clr_we     (clr_we),
    .clr_mask   (clr_mask),
    .flag_d_o   (flag_d),
    .flag_q_o   (flags)
  );

  uirq_req_combine u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .flag_d (flag_d),
    .flag_q (flags),
    .src_en (src_en),
    .glb_en (glb_en),
    .irq_o  (irq)
  );

  for (genvar k = NUM_LVL_SRC; k < NUM_STAT; k++) begin : g_dma_chk
    p_dma_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stat[k]) |=> flags[k]);
  end

  p_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |=> flags[B_PARITY]);
  p_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> flags[B_FRAME]);
  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err |=> flags[B_OVERRUN]);

endmodule

// File: tb/sim_uart_irq_events.sv
`timescale 1ns/1ps
module sim_uart_irq_events;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, level_mode, tx_idle, tx_free, rx_avail;
  logic [1:0] tx_buf_busy, rx_buf_busy;
  logic       parity_err, frame_err, overrun_err, clr_we, glb_en;
  logic [9:0] clr_mask, src_en, flags;
  logic       irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  uart_irq_events u0 (
    .clk(clk), .rst_n(rst_n), .level_mode(level_mode), .tx_idle(tx_idle),
    .tx_free(tx_free), .rx_avail(rx_avail), .tx_buf_busy(tx_buf_busy),
    .rx_buf_busy(rx_buf_busy), .parity_err(parity_err), .frame_err(frame_err),
    .overrun_err(overrun_err), .clr_we(clr_we), .clr_mask(clr_mask),
    .src_en(src_en), .glb_en(glb_en), .flags(flags), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [6:0] m_prev  = '0;
  logic [9:0] m_flags = '0;
  logic       m_irq   = 1'b0;

  always @(posedge clk) begin : model
    logic [6:0] s;
    logic [9:0] nf;
    logic [2:0] pulses;
    s      = {rx_buf_busy, tx_buf_busy, rx_avail, tx_free, tx_idle};
    pulses = {overrun_err, frame_err, parity_err};
    if (!rst_n) begin
      m_flags = '0;
      m_irq   = 1'b0;
    end else begin
      nf = m_flags;
      for (int i = 0; i < 10; i++) begin
        if (i < 3 && level_mode) begin
          nf[i] = s[i];
        end else begin
          if (clr_we && clr_mask[i]) nf[i] = 1'b0;
          if (i < 3 && s[i] && !m_prev[i]) nf[i] = 1'b1;
          if (i >= 3 && i < 7 && !s[i] && m_prev[i]) nf[i] = 1'b1;
          if (i >= 7 && pulses[i-7]) nf[i] = 1'b1;
        end
      end
      m_flags = nf;
      m_irq   = glb_en && ((nf & src_en) != 10'd0);
    end
    m_prev = s;
  end

  function automatic string req_of(int b);
    if (b < 3)       return level_mode ? "R3" : "R2";
    else if (b < 7)  return "R4";
    else             return "R5";
  endfunction

  always @(negedge clk) begin
    if (!done) begin
      n_tests++;
      if (flags !== m_flags || irq !== m_irq) begin
        n_fail++;
        for (int b = 0; b < 10; b++)
          if (flags[b] !== m_flags[b])
            $display("FAIL %s model compare flag[%0d]: actual %b expected %b",
                     req_of(b), b, flags[b], m_flags[b]);
        if (irq !== m_irq)
          $display("FAIL R8 model compare irq: actual %b expected %b", irq, m_irq);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic cyc();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog expired");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 0; level_mode = 0; tx_idle = 1; tx_free = 1; rx_avail = 0;
    tx_buf_busy = 2'b11; rx_buf_busy = 2'b11;
    parity_err = 0; frame_err = 0; overrun_err = 0;
    clr_we = 0; clr_mask = '0; src_en = '0; glb_en = 0;

    repeat (3) cyc();
    chk("R1", "flags in reset", 32'(flags), 0);
    chk("R1", "irq in reset", 32'(irq), 0);

    rst_n = 1;
    cyc(); cyc();
    chk("R7", "no false edge after reset", 32'(flags), 0);

    tx_idle = 0; cyc();
    tx_idle = 1; cyc();
    chk("R2", "tx_idle rise sets bit 0", 32'(flags[0]), 1);
    chk("R2", "tx_free held high stays 0", 32'(flags[1]), 0);

    clr_we = 1; clr_mask = 10'h001; cyc();
    clr_we = 0; clr_mask = '0;
    chk("R6", "clear bit 0", 32'(flags[0]), 0);
    cyc();
    chk("R2", "steady high does not refire", 32'(flags[0]), 0);

    tx_buf_busy = 2'b10; cyc();
    chk("R4", "tx buffer A done sets bit 3", 32'(flags[4:3]), 32'h1);
    rx_buf_busy = 2'b01; cyc();
    chk("R4", "rx buffer B done sets bit 6", 32'(flags[6]), 1);

    parity_err = 1; cyc();
    parity_err = 0;
    chk("R5", "parity error sets bit 7", 32'(flags[7]), 1);

    parity_err = 1; clr_we = 1; clr_mask = 10'h080; cyc();
    parity_err = 0; clr_we = 0;
    chk("R6", "set wins over clear", 32'(flags[7]), 1);

    clr_we = 1; clr_mask = 10'h048; cyc();
    clr_we = 0;
    chk("R6", "bits 3 and 6 cleared", 32'({flags[6], flags[3]}), 0);
    chk("R6", "unmasked bit 7 kept", 32'(flags[7]), 1);

    level_mode = 1; rx_avail = 1; cyc();
    chk("R3", "level follows rx_avail", 32'(flags[2]), 1);
    chk("R3", "level follows tx_idle", 32'(flags[0]), 1);
    clr_we = 1; clr_mask = 10'h004; cyc();
    clr_we = 0;
    chk("R3", "clear ignored in level mode", 32'(flags[2]), 1);
    rx_avail = 0; cyc();
    chk("R3", "level drops with signal", 32'(flags[2]), 0);

    level_mode = 0; src_en = 10'h080; glb_en = 1; cyc();
    chk("R8", "irq from enabled bit 7", 32'(irq), 1);
    glb_en = 0; cyc();
    chk("R9", "global disable blocks irq", 32'(irq), 0);
    chk("R9", "flag kept while disabled", 32'(flags[7]), 1);

    glb_en = 1; src_en = 10'h200; cyc();
    chk("R8", "no irq without enabled flag", 32'(irq), 0);
    overrun_err = 1; cyc();
    overrun_err = 0;
    chk("R8", "irq same cycle as flag", 32'(irq), 1);
    chk("R5", "overrun sets bit 9", 32'(flags[9]), 1);

    for (int t = 0; t < 4000; t++) begin
      if ($urandom_range(0, 3) == 0) tx_idle  = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 3) == 0) tx_free  = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 3) == 0) rx_avail = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 3) == 0) tx_buf_busy = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) rx_buf_busy = 2'($urandom_range(0, 3));
      parity_err  = $urandom_range(0, 7) == 0;
      frame_err   = $urandom_range(0, 7) == 0;
      overrun_err = $urandom_range(0, 7) == 0;
      clr_we      = $urandom_range(0, 2) == 0;
      clr_mask    = 10'($urandom);
      if ($urandom_range(0, 49) == 0) level_mode = ~level_mode;
      if ($urandom_range(0, 9) == 0)  src_en = 10'($urandom);
      if ($urandom_range(0, 19) == 0) glb_en = ~glb_en;
      cyc();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule